// File: doc/BRIEF.md
# Burst Memory Latency Responder

This block stands in for the next memory level behind a cache refill path and keeps its cycle timing exact. A requester presents a word address together with a direction (read or write) and a length (one word or a full burst). The block waits out the address transfer time and the first-access latency, and then completes the words of the block one by one. A fixed spacing separates the words, and one transfer cycle is added to each. With the default timing, a one-word miss takes 52 cycles from acceptance to completion and a four-word burst takes 82.

The burst words come from consecutive word addresses, starting at the requested address and wrapping at the top of a small internal storage array. A read burst presents each word on the response port for one cycle. A write burst uses exactly the same beat schedule: it pulses a take strobe in each beat cycle and stores whatever is on the write-data input at the end of that cycle. Only one request is handled at a time. A request presented while the block is busy has no effect.

Top module: `burst_mem_resp`

## Requirements
- R1: After reset, `busy`, `rsp_valid`, `wr_take` and `beat_last` are all low.
- R2: A request is taken only in a cycle where `req_valid` is high and `busy` is low, and `busy` is high in the next cycle. A request presented while `busy` is high, including in the final busy cycle, changes no timing and no stored data, and starts no new operation.
- R3: For a one-word read, counting the first cycle after the accepting edge as cycle 1, `rsp_valid` is high only in cycle ADDR_CYC+FIRST_CYC+XFER_CYC (52 by default). `beat_last` is high in that same cycle.
- R4: For a four-word burst (`req_burst`=1), the beats fall in cycles 52, 62, 72 and 82 with the defaults: the first beat at the single-word latency, then one beat every GAP_CYC cycles. `beat_last` is high only on the fourth beat.
- R5: Beat k of an operation (k counted from 0) uses the word address (`req_addr` + k) modulo 2^AW, so a burst crosses from the last word back to word 0.
- R6: `busy` stays high from cycle 1 through the cycle of the final beat. That is 52 cycles for one word and 82 for a burst by default. `busy` is low in the cycle after the final beat, and a new request can be accepted in that cycle.
- R7: A write (`req_write`=1) pulses `wr_take` in exactly the beat cycles that a read would use. The value on `wr_data` in each such cycle is stored at that beat's address, and a later read returns it.
- R8: `rsp_data` is zero in every cycle where `rsp_valid` is low.
- R9: After reset, every storage word reads as zero.
- R10: `rsp_valid` is never high during a write, and `wr_take` is never high during a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write operation, 0 = read operation |
| req_burst | input | 1 | 1 = BURST_LEN words, 0 = one word |
| req_addr | input | AW | Starting word address |
| wr_data | input | DW | Write word, stored at the end of a `wr_take` cycle |
| busy | output | 1 | Operation in progress |
| wr_take | output | 1 | Write beat: `wr_data` is stored at this edge |
| rsp_valid | output | 1 | Read beat: `rsp_data` holds a word |
| rsp_data | output | DW | Read word, zero outside read beats |
| beat_last | output | 1 | Current beat is the final one of the operation |

## Verification
The hardest situation to produce is a new request that arrives in the very cycle the final beat completes. At that moment `busy` is still high, so the request must be dropped, even though it would be taken one cycle later. The stimulus places such a request on exactly that cycle, and also on the first busy cycle and on randomly chosen busy cycles. Each such request carries a different direction and address. The stimulus then checks that `busy` stays low afterwards and that later reads show no stray write. Bursts that start near the top address exercise the wrap from the last word back to word 0.

// File: rtl/burst_mem_pkg.sv
package burst_mem_pkg;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } op_e;

    // total cycles from the accepting edge to the final beat
    function automatic int unsigned op_span(input int unsigned lat,
                                            input int unsigned gap,
                                            input int unsigned beats);
        return lat + (beats - 1) * gap;
    endfunction

endpackage

// File: rtl/bm_beat_timer.sv
module bm_beat_timer #(
    parameter int FIRST_LOAD = 51,
    parameter int GAP_LOAD   = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_first,
    input  logic load_gap,
    output logic due
);
    localparam int MAXV = (FIRST_LOAD > GAP_LOAD) ? FIRST_LOAD : GAP_LOAD;
    localparam int CW   = (MAXV > 0) ? $clog2(MAXV + 1) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_first) begin
            cnt_d = CW'(FIRST_LOAD);
        end else if (load_gap) begin
            cnt_d = CW'(GAP_LOAD);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign due = (cnt_q == '0);

endmodule

// File: rtl/bm_word_store.sv
module bm_word_store #(
    parameter int DW = 32,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];

endmodule

// File: rtl/burst_mem_resp.sv
module burst_mem_resp
    import burst_mem_pkg::*;
#(
    parameter int DW        = 32,
    parameter int AW        = 6,
    parameter int BURST_LEN = 4,
    parameter int ADDR_CYC  = 1,
    parameter int FIRST_CYC = 50,
    parameter int GAP_CYC   = 10,
    parameter int XFER_CYC  = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_burst,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] wr_data,
    output logic          busy,
    output logic          wr_take,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          beat_last
);
    localparam int LAT = ADDR_CYC + FIRST_CYC + XFER_CYC;
    localparam int BW  = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

    typedef struct packed {
        logic          busy;
        op_e           op;
        logic [BW-1:0] last_idx;
        logic [BW-1:0] idx;
        logic [AW-1:0] addr;
    } ctl_t;

    ctl_t          ctl_d, ctl_q;
    logic          load_first, load_gap, due;
    logic          accept, beat, final_beat;
    logic [DW-1:0] store_rdata;

    assign accept     = req_valid && !ctl_q.busy;
    assign beat       = ctl_q.busy && due;
    assign final_beat = beat && (ctl_q.idx == ctl_q.last_idx);

    always_comb begin
        ctl_d      = ctl_q;
        load_first = 1'b0;
        load_gap   = 1'b0;
        if (accept) begin
            ctl_d.busy     = 1'b1;
            ctl_d.op       = req_write ? OP_WRITE : OP_READ;
            ctl_d.last_idx = req_burst ? BW'(BURST_LEN - 1) : '0;
            ctl_d.idx      = '0;
            ctl_d.addr     = req_addr;
            load_first     = 1'b1;
        end else if (beat) begin
            ctl_d.addr = ctl_q.addr + 1'b1;
            if (final_beat) begin
                ctl_d.busy = 1'b0;
            end else begin
                ctl_d.idx = ctl_q.idx + 1'b1;
                load_gap  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    bm_beat_timer #(
        .FIRST_LOAD (LAT - 1),
        .GAP_LOAD   (GAP_CYC - 1)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_first (load_first),
        .load_gap   (load_gap),
        .due        (due)
    );

    bm_word_store #(
        .DW    (DW),
        .AW    (AW)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_take),
        .addr  (ctl_q.addr),
        .wdata (wr_data),
        .rdata (store_rdata)
    );

    assign busy      = ctl_q.busy;
    assign rsp_valid = beat && (ctl_q.op == OP_READ);
    assign wr_take   = beat && (ctl_q.op == OP_WRITE);
    assign beat_last = final_beat;
    assign rsp_data  = rsp_valid ? store_rdata : '0;

endmodule

// File: rtl/burst_mem_resp_chk.sv
module burst_mem_resp_chk #(
    parameter int DW        = 32,
    parameter int AW        = 6,
    parameter int ADDR_CYC  = 1,
    parameter int FIRST_CYC = 50,
    parameter int GAP_CYC   = 10,
    parameter int XFER_CYC  = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [AW-1:0] req_addr,
    input logic          busy,
    input logic          wr_take,
    input logic          rsp_valid,
    input logic [DW-1:0] rsp_data,
    input logic          beat_last
);
    localparam int unsigned LAT = ADDR_CYC + FIRST_CYC + XFER_CYC;

    int unsigned since_q, gap_q;
    logic        seen_q;
    logic        any_beat;

    assign any_beat = rsp_valid || wr_take;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= 0;
            gap_q   <= 0;
            seen_q  <= 1'b0;
        end else begin
            if (req_valid && !busy) begin
                since_q <= 1;
                seen_q  <= 1'b0;
            end else begin
                if (busy && since_q != 32'hFFFF_FFFF) since_q <= since_q + 1;
                if (any_beat) seen_q <= 1'b1;
            end
            if (any_beat) gap_q <= 1;
            else if (gap_q != 32'hFFFF_FFFF) gap_q <= gap_q + 1;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rsp_valid && !wr_take && !beat_last));

    p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    p_hold_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !beat_last) |=> busy);

    p_first_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (any_beat && !seen_q) |-> (since_q == LAT));

    p_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (any_beat && seen_q) |-> (gap_q == GAP_CYC));

    p_end_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |=> !busy);

    p_zero_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_data == '0));

    p_excl_dir_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && wr_take));

    p_last_is_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |-> any_beat);

    logic unused_ok;
    assign unused_ok = ^req_addr;

endmodule

bind burst_mem_resp burst_mem_resp_chk #(
    .DW        (DW),
    .AW        (AW),
    .ADDR_CYC  (ADDR_CYC),
    .FIRST_CYC (FIRST_CYC),
    .GAP_CYC   (GAP_CYC),
    .XFER_CYC  (XFER_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .busy      (busy),
    .wr_take   (wr_take),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .beat_last (beat_last)
);

// File: tb/tb_burst_mem_resp.sv
`timescale 1ns/1ps
module tb_burst_mem_resp;
    localparam int DW  = 32;
    localparam int AW  = 6;
    localparam int LAT = 52;
    localparam int GAP = 10;
    localparam int NB  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic          req_burst = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          busy, wr_take, rsp_valid, beat_last;
    logic [DW-1:0] rsp_data;

    logic [DW-1:0] model [1 << AW];
    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    burst_mem_resp #(
        .DW(DW), .AW(AW), .BURST_LEN(NB),
        .ADDR_CYC(1), .FIRST_CYC(50), .GAP_CYC(GAP), .XFER_CYC(1)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_burst(req_burst), .req_addr(req_addr), .wr_data(wr_data),
        .busy(busy), .wr_take(wr_take), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .beat_last(beat_last)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic int beat_of(input int cyc, input int n);
        if (cyc >= LAT && ((cyc - LAT) % GAP) == 0 && ((cyc - LAT) / GAP) < n)
            return (cyc - LAT) / GAP;
        return -1;
    endfunction

    // Called at a falling edge with busy low; returns at the falling edge
    // of the first idle cycle after the operation.
    task automatic run_op(input bit wr, input bit bur, input logic [AW-1:0] a,
                          input int poke, input string tag);
        int n;
        int total;
        n = bur ? NB : 1;
        total = LAT + (n - 1) * GAP;
        req_valid = 1'b1; req_write = wr; req_burst = bur; req_addr = a;
        @(negedge clk);
        for (int cyc = 1; cyc <= total + 1; cyc++) begin
            int k;
            logic [AW-1:0] ba;
            k = beat_of(cyc, n);
            ba = AW'(a + AW'(k));
            if (cyc == poke) begin
                req_valid = 1'b1; req_write = ~wr; req_burst = ~bur;
                req_addr = AW'($urandom);
            end else begin
                req_valid = 1'b0;
            end
            chk(busy == (cyc <= total), "R6", "busy level", DW'(busy), DW'(cyc <= total));
            if (k >= 0 && !wr) begin
                chk(rsp_valid == 1'b1, bur ? "R4" : "R3", "read beat", DW'(rsp_valid), 1);
                chk(rsp_data == model[ba], tag, "read word", rsp_data, model[ba]);
                chk(beat_last == (k == n - 1), "R4", "last flag", DW'(beat_last), DW'(k == n - 1));
                chk(wr_take == 1'b0, "R10", "no take on read", DW'(wr_take), 0);
                wr_data = $urandom;
            end else if (k >= 0 && wr) begin
                logic [DW-1:0] v;
                v = $urandom;
                chk(wr_take == 1'b1, "R7", "write beat", DW'(wr_take), 1);
                chk(rsp_valid == 1'b0, "R10", "no read on write", DW'(rsp_valid), 0);
                chk(beat_last == (k == n - 1), "R4", "last flag", DW'(beat_last), DW'(k == n - 1));
                wr_data = v;
                model[ba] = v;
            end else begin
                chk(!rsp_valid && !wr_take, bur ? "R4" : "R3", "no beat",
                    DW'({rsp_valid, wr_take}), 0);
                chk(rsp_data == '0, "R8", "idle data", rsp_data, 0);
                wr_data = $urandom;
            end
            if (cyc <= total) @(negedge clk);
        end
        if (poke > 0) begin
            for (int j = 0; j < 3; j++) begin
                @(negedge clk);
                chk(!busy && !rsp_valid && !wr_take, "R2", "ignored request",
                    DW'({busy, rsp_valid, wr_take}), 0);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < (1 << AW); i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !rsp_valid && !wr_take && !beat_last, "R1", "reset outputs",
            DW'({busy, rsp_valid, wr_take, beat_last}), 0);
        // R9 unwritten word reads zero
        run_op(1'b0, 1'b0, 6'd5, 0, "R9");
        // R7 single write then read back, back to back
        run_op(1'b1, 1'b0, 6'd7, 0, "R7");
        run_op(1'b0, 1'b0, 6'd7, 0, "R7");
        // R5 burst write across the top address, then read it
        run_op(1'b1, 1'b1, 6'd62, 0, "R5");
        run_op(1'b0, 1'b1, 6'd62, 0, "R5");
        run_op(1'b0, 1'b1, 6'd60, 0, "R5");
        // R2 request in the final busy cycle and in the first
        run_op(1'b0, 1'b1, 6'd61, LAT + (NB - 1) * GAP, "R2");
        run_op(1'b1, 1'b0, 6'd0, 1, "R2");
        run_op(1'b0, 1'b1, 6'd63, 0, "R5");
        // random mix
        for (int i = 0; i < 40; i++) begin
            bit w, b;
            int p;
            w = 1'($urandom);
            b = 1'($urandom);
            p = (($urandom % 4) == 0) ? 1 + int'($urandom % (b ? 82 : 52)) : 0;
            run_op(w, b, AW'($urandom), p, b ? "R5" : "R7");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule